// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable single-port synchronous SRAM. The bus never needs an idle cycle when it changes between reads and writes. Address and control are captured on a rising clock edge. The data transfer for that operation takes place two enabled edges later, and the same rule applies to reads and writes. Because the write data trails its address by the same distance as read data, a controller can issue any mix of reads and writes on consecutive cycles.

A new operation starts only when the load control is low and all three chip selects are active. Every other enabled cycle is a deselect, and a deselect still lets the operations already in the pipeline finish. A clock enable freezes the whole block, including the data on the output and the state of the bus driver. The bidirectional data bus is split into an input, an output and a drive enable. An asynchronous output enable can switch the driver off at any moment.

Top module: `zt_sram`

## Requirements
- R1: A read sampled at enabled edge E places the word on `dq_out` at enabled edge E+2, and `dq_oe` is high from then until the next enabled edge (when `oe_n` is low).
- R2: For a write sampled at enabled edge E, `dq_in` is taken at enabled edge E+2.
- R3: Reads and writes may be issued on every consecutive enabled cycle in any order. No idle cycle is needed, and each read returns every earlier write in issue order.
- R4: An operation starts only when `ld_n`=0, `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Any other combination is a deselect, which neither writes nor drives the bus.
- R5: A deselect does not cancel reads or writes issued before it. They complete with the normal timing.
- R6: The driver turns off at enabled edge E+2 when edge E sampled a deselect or a write.
- R7: `oe_n`=1 forces `dq_oe` low at once, with no clock edge needed. The pipeline is not disturbed.
- R8: `bw_n[i]` is active low and gates lane i, bits [i*9 +: 9] of the data word. It is sampled with the address, and its value during the data cycle has no effect.
- R9: A read issued the cycle after a write to the same address returns the newly written lanes, merged with the untouched lanes.
- R10: While `cen_n`=1, every synchronous input is ignored, including `dq_in`, and all registers hold. `dq_out` and `dq_oe` stay unchanged.
- R11: The synchronous active-high `rst` empties the pipeline and turns the driver off. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low |
| ld_n | input | 1 | Load a new operation, active low |
| cs_a_n | input | 1 | Chip select A, active low |
| cs_b | input | 1 | Chip select B, active high |
| cs_c_n | input | 1 | Chip select C, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The timing properties assume that reset is applied synchronously for at least one edge before traffic starts. They also assume that `cen_n` is stable around each edge, so the number of enabled edges between an address and its data phase can be counted. The latency checks therefore only claim a result when the clock enable is active on each of the two edges that follow an issue. The stimulus drives every input at the falling edge. It changes `oe_n` only between edges and never during a stalled cycle. Before any read it fills every address, so no read returns an unwritten word.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // all selects active and load requested
  function automatic logic sel_ok(input logic ld_n, input logic a_n,
                                  input logic b, input logic c_n);
    return !ld_n && !a_n && b && !c_n;
  endfunction

endpackage

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen_n,
  input  logic              ld_n,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              cs_c_n,
  input  logic              rd_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [LANES-1:0]  s2_be
);

  op_e              issue_op;
  logic [LANES-1:0] s1_be;

  always_comb begin
    if (!sel_ok(ld_n, cs_a_n, cs_b, cs_c_n)) issue_op = OP_NONE;
    else if (rd_wr_n)                         issue_op = OP_READ;
    else                                      issue_op = OP_WRITE;
  end

  // operation kind: reset to empty, frozen while clock enable is off
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op <= OP_NONE;
      s2_op <= OP_NONE;
    end else if (!cen_n) begin
      s1_op <= issue_op;
      s2_op <= s1_op;
    end
  end

  // address and lane selects travel with the operation
  always_ff @(posedge clk) begin
    if (!cen_n) begin
      s1_addr <= addr;
      s1_be   <= ~bw_n;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

endmodule

// File: rtl/zt_lane_ram.sv
module zt_lane_ram #(
  parameter int ADDR_W = 6,
  parameter int WIDTH  = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [0:DEPTH-1];

  // one write port, one registered read port (read returns old contents)
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/zt_data_path.sv
module zt_data_path
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cen_n,
  input  op_e                     s1_op,
  input  logic [ADDR_W-1:0]       s1_addr,
  input  op_e                     s2_op,
  input  logic [ADDR_W-1:0]       s2_addr,
  input  logic [LANES-1:0]        s2_be,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    drv
);

  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] fwd_data;
  logic [LANES-1:0]  fwd_be;
  logic              fwd_hit;
  logic              rd_en;
  logic              wr_go;

  assign rd_en = !cen_n && (s1_op == OP_READ);
  assign wr_go = !cen_n && (s2_op == OP_WRITE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    zt_lane_ram #(
      .ADDR_W(ADDR_W),
      .WIDTH (LANE_W)
    ) u_ram (
      .clk  (clk),
      .we   (wr_go && s2_be[g]),
      .waddr(s2_addr),
      .wdata(din[g*LANE_W +: LANE_W]),
      .re   (rd_en),
      .raddr(s1_addr),
      .rdata(ram_q[g*LANE_W +: LANE_W])
    );

    // lanes written on the same edge as the array read come from the bypass
    assign merged[g*LANE_W +: LANE_W] = (fwd_hit && fwd_be[g]) ?
                                        fwd_data[g*LANE_W +: LANE_W] :
                                        ram_q[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit <= 1'b0;
      drv     <= 1'b0;
      dout    <= '0;
    end else if (!cen_n) begin
      fwd_hit  <= (s1_op == OP_READ) && (s2_op == OP_WRITE) && (s1_addr == s2_addr);
      fwd_be   <= s2_be;
      fwd_data <= din;
      drv      <= (s2_op == OP_READ);
      if (s2_op == OP_READ) dout <= merged;
    end
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cen_n,
  input  logic                    ld_n,
  input  logic                    cs_a_n,
  input  logic                    cs_b,
  input  logic                    cs_c_n,
  input  logic                    rd_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  op_e               s1_op;
  op_e               s2_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_be;
  logic              rd_drv;

  zt_cmd_pipe #(
    .ADDR_W(ADDR_W),
    .LANES (LANES)
  ) u_pipe (
    .clk    (clk),
    .rst    (rst),
    .cen_n  (cen_n),
    .ld_n   (ld_n),
    .cs_a_n (cs_a_n),
    .cs_b   (cs_b),
    .cs_c_n (cs_c_n),
    .rd_wr_n(rd_wr_n),
    .addr   (addr),
    .bw_n   (bw_n),
    .s1_op  (s1_op),
    .s1_addr(s1_addr),
    .s2_op  (s2_op),
    .s2_addr(s2_addr),
    .s2_be  (s2_be)
  );

  zt_data_path #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_data (
    .clk    (clk),
    .rst    (rst),
    .cen_n  (cen_n),
    .s1_op  (s1_op),
    .s1_addr(s1_addr),
    .s2_op  (s2_op),
    .s2_addr(s2_addr),
    .s2_be  (s2_be),
    .din    (dq_in),
    .dout   (dq_out),
    .drv    (rd_drv)
  );

  // asynchronous gate on the registered driver state
  assign dq_oe = rd_drv & ~oe_n;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_sram_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              cen_n,
  input logic              ld_n,
  input logic              cs_a_n,
  input logic              cs_b,
  input logic              cs_c_n,
  input logic              rd_wr_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              rd_drv,
  input op_e               s1_op
);

  logic start_any;
  logic start_rd;

  assign start_any = !cen_n && sel_ok(ld_n, cs_a_n, cs_b, cs_c_n);
  assign start_rd  = start_any && rd_wr_n;

  assert_read_drives_R1: assert property (@(posedge clk) disable iff (rst)
    start_rd ##1 !cen_n ##1 !cen_n |=> rd_drv);

  assert_drive_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !start_rd) ##1 !cen_n ##1 !cen_n |=> !rd_drv);

  assert_deselect_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !start_any) |=> (s1_op == OP_NONE));

  assert_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    cen_n |=> ($stable(dq_out) && $stable(rd_drv)));

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!rd_drv && s1_op == OP_NONE));

endmodule

bind zt_sram zt_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cen_n  (cen_n),
  .ld_n   (ld_n),
  .cs_a_n (cs_a_n),
  .cs_b   (cs_b),
  .cs_c_n (cs_c_n),
  .rd_wr_n(rd_wr_n),
  .dq_out (dq_out),
  .rd_drv (rd_drv),
  .s1_op  (s1_op)
);

// File: tb/tb_zt_sram.sv
module tb_zt_sram;

  localparam int AW = 6;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic          clk = 1'b0;
  logic          rst;
  logic          cen_n;
  logic          ld_n;
  logic          cs_a_n;
  logic          cs_b;
  logic          cs_c_n;
  logic          rd_wr_n;
  logic [AW-1:0] addr;
  logic [LN-1:0] bw_n;
  logic          oe_n;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  always #10 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
    .clk(clk), .rst(rst), .cen_n(cen_n), .ld_n(ld_n),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n), .rd_wr_n(rd_wr_n),
    .addr(addr), .bw_n(bw_n), .oe_n(oe_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int            total = 0;
  int            bad = 0;
  int            en_cnt = 0;
  bit            last_en = 0;
  bit            mon_on = 0;
  string         phase = "R11";
  logic [DW-1:0] model [64];
  logic [DW-1:0] wdue [8];
  bit            drv_due [8];
  int            due_q [$];
  logic [DW-1:0] val_q [$];
  logic [DW-1:0] prev_out = '0;
  logic          prev_oe = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // count enabled edges as the requirements define them
  always @(posedge clk) begin
    last_en <= !rst && !cen_n;
    if (rst) en_cnt <= 0;
    else if (!cen_n) en_cnt <= en_cnt + 1;
  end

  // driver: one bus cycle; pushes expected results for the monitor
  task automatic cyc(input bit en, input bit ld, input int csm, input bit rd,
                     input int ad, input logic [LN-1:0] bw, input logic [DW-1:0] wd);
    int e;
    bit go;
    @(negedge clk);
    cen_n   = !en;
    ld_n    = ld;
    cs_a_n  = (csm == 1);
    cs_b    = (csm != 2);
    cs_c_n  = (csm == 3);
    rd_wr_n = rd;
    addr    = ad[AW-1:0];
    bw_n    = bw;
    if (en) begin
      e = en_cnt + 1;
      dq_in = wdue[e % 8];
      go = !ld && (csm == 0);
      drv_due[(e + 2) % 8] = go && rd;
      if (go && rd) begin
        due_q.push_back(e + 2);
        val_q.push_back(model[ad]);
      end
      if (go && !rd) begin
        for (int i = 0; i < LN; i++)
          if (!bw[i]) model[ad][i*LW +: LW] = wd[i*LW +: LW];
        wdue[(e + 2) % 8] = wd;
      end
    end else begin
      dq_in = DW'($urandom);
    end
  endtask

  task automatic rd(input int a);
    cyc(1'b1, 1'b0, 0, 1'b1, a, '1, '0);
  endtask

  task automatic wr(input int a, input logic [LN-1:0] bw, input logic [DW-1:0] d);
    cyc(1'b1, 1'b0, 0, 1'b0, a, bw, d);
  endtask

  task automatic idle();
    cyc(1'b1, 1'b1, 0, 1'b1, 0, '0, '0);
  endtask

  task automatic stall();
    cyc(1'b0, 1'b0, 0, 1'($urandom), 16, '0, DW'($urandom));
  endtask

  // monitor: samples 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (mon_on) begin
      if (last_en) begin
        chk(dq_oe == (drv_due[en_cnt % 8] && !oe_n), "R6 drive state",
            DW'(dq_oe), DW'(drv_due[en_cnt % 8] && !oe_n));
        if (due_q.size() > 0 && due_q[0] == en_cnt) begin
          chk(dq_out == val_q[0], {phase, " read data"}, dq_out, val_q[0]);
          due_q.delete(0);
          val_q.delete(0);
        end
      end else begin
        chk(dq_out == prev_out && dq_oe == prev_oe, "R10 outputs held while stalled",
            dq_out, prev_out);
      end
    end
    prev_out = dq_out;
    prev_oe  = dq_oe;
  end

  initial begin
    rst = 1'b1; cen_n = 1'b1; ld_n = 1'b1; cs_a_n = 1'b0; cs_b = 1'b1; cs_c_n = 1'b0;
    rd_wr_n = 1'b1; addr = '0; bw_n = '1; oe_n = 1'b0; dq_in = '0;
    for (int i = 0; i < 8; i++) begin
      wdue[i] = '0;
      drv_due[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    cen_n = 1'b0;
    @(negedge clk);
    chk(dq_oe == 1'b0, "R11 driver off after reset", DW'(dq_oe), '0);
    chk(dq_out == '0, "R11 output cleared by reset", dq_out, '0);
    rst = 1'b0;
    cen_n = 1'b1;
    mon_on = 1'b1;

    phase = "R2 write data two edges late";
    for (int a = 0; a < 64; a++) wr(a, '0, DW'(a * 1237 + 77));
    phase = "R1 read latency";
    for (int a = 0; a < 64; a++) rd(a);

    phase = "R3 alternating traffic";
    for (int i = 0; i < 16; i++) begin
      wr(i + 20, '0, DW'(i * 311 + 9));
      rd(i + 40);
    end

    phase = "R9 read right after write";
    wr(7, '0, 18'h2a5a5);
    rd(7);
    wr(8, 2'b01, 18'h1ffff);
    rd(8);
    rd(9);
    wr(9, '0, 18'h01234);
    rd(9);
    wr(11, '0, 18'h15555);
    wr(11, 2'b10, 18'h0aaaa);
    rd(11);

    phase = "R8 lane selects taken with address";
    wr(12, 2'b10, 18'h3c3c3);
    cyc(1'b1, 1'b1, 0, 1'b0, 12, '0, '0);
    cyc(1'b1, 1'b1, 0, 1'b0, 12, '0, '0);
    rd(12);
    wr(13, 2'b01, 18'h3fe00);
    rd(13);

    phase = "R4 deselect";
    for (int m = 1; m < 4; m++) begin
      cyc(1'b1, 1'b0, m, 1'b0, 14, '0, 18'h3ffff);
      cyc(1'b1, 1'b0, m, 1'b1, 14, '0, '0);
    end
    cyc(1'b1, 1'b1, 0, 1'b0, 14, '0, 18'h3ffff);
    idle();
    idle();
    rd(14);

    phase = "R5 pending work survives deselect";
    rd(15);
    cyc(1'b1, 1'b0, 2, 1'b1, 0, '0, '0);
    idle();
    wr(15, '0, 18'h0f0f0);
    cyc(1'b1, 1'b0, 3, 1'b1, 0, '0, '0);
    idle();
    rd(15);
    idle();
    idle();

    phase = "R10 stall";
    rd(16);
    stall();
    stall();
    rd(17);
    stall();
    wr(18, '0, 18'h24924);
    stall();
    stall();
    idle();
    stall();
    idle();
    rd(18);
    rd(16);
    idle();
    idle();

    phase = "R7 output enable";
    rd(1);
    rd(2);
    rd(3);
    @(posedge clk);
    #2;
    oe_n = 1'b1;
    #1;
    chk(dq_oe == 1'b0, "R7 output enable forces driver off", DW'(dq_oe), '0);
    oe_n = 1'b0;
    #1;
    chk(dq_oe == 1'b1, "R7 driver returns with output enable", DW'(dq_oe), 1);
    rd(4);
    idle();
    idle();

    phase = "R3 random mix";
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom % 10;
      if (r == 0) stall();
      else if (r == 1) cyc(1'b1, 1'($urandom), int'($urandom % 4), 1'($urandom),
                           int'($urandom % 16), LN'($urandom), DW'($urandom));
      else if (r < 6) rd(int'($urandom % 16));
      else wr(int'($urandom % 16), LN'($urandom), DW'($urandom));
    end
    repeat (4) idle();
    chk(due_q.size() == 0, "R1 every read returned", DW'(due_q.size()), '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule